// File: doc/BRIEF.md
# Dual-half NAND Hamming ECC generator

This block computes a single-error-correcting Hamming code over a 512-byte NAND sector while the sector's bytes stream through the data path. The sector is split into two independent 256-byte halves. Each half yields 16 line-parity bits and 6 column-parity bits, so the sector yields 6 code bytes in total. All parity bits are kept in inverted form. As a result, an erased half (all 0xFF) produces all-ones code bytes.

The block is steered by 8-bit mode codes written on a mode port. Code 0xF4 clears the accumulators, and a single dummy data read must follow it. Code 0xB4 starts accumulation. Code 0xD4 switches reads to result readout. Code 0x94 returns the data register to normal transfers. In readout, successive read requests return three 16-bit words, in which the code bytes of the two halves are interleaved in a fixed order.

Top module: `nand_ecc_gen`

## Requirements
- R1: After rst the block is in data mode with no reset pending, rd_valid is 0, and an immediate readout (0xD4 followed by reads) returns 0xFFFF in every word.
- R2: Writing 0xF4 clears both halves' accumulators and the byte counter, and marks a reset as pending. The first rd_req while a reset is pending is a dummy read: it clears the pending mark and gives no rd_valid. While a reset is pending, 0xB4 is ignored and streamed bytes are not accumulated.
- R3: A byte with byte_valid high is accumulated only in accumulate mode. Bytes offered in data mode are ignored. Writing 0xB4 from data mode, with no reset pending, resumes accumulation and keeps the parity gathered so far.
- R4: An internal byte counter picks the half for each accumulated byte. Indices 0 to 255 go to half A and 256 to 511 go to half B. The counter wraps at 512, so byte 512 goes to half A again with in-half index 0.
- R5: Within a half, line-parity bit LP(2k+1) is the inverted XOR of the parity of every byte whose in-half index has bit k set. LP(2k) is the same over bytes whose index has bit k clear, for k = 0..7.
- R6: Within a half, column bit CP(2j+1) is the inverted XOR of all data bits whose bit position within the byte has bit j set. CP(2j) covers the positions with bit j clear, for j = 0..2. The column byte is {CP5,CP4,CP3,CP2,CP1,CP0,1,1}.
- R7: The result words are arranged as follows. Word 0 = {LP15..8 of A, LP7..0 of A}. Word 1 = {LP7..0 of B, column byte of A}. Word 2 = {column byte of B, LP15..8 of B}.
- R8: Writing 0xD4 enters readout with the word index at 0. Each rd_req returns the next word on rd_data, with rd_valid high, in the cycle after the request. The order is 0, 1, 2, then back to 0.
- R9: Writing 0x94 leaves readout. rd_req then gives no rd_valid, and a later 0xD4 starts again from word 0.
- R10: A sector of 512 bytes of 0xFF reads back as 0xFFFF in all three words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode code write strobe |
| mode_code | input | 8 | Mode code (0xF4, 0xB4, 0xD4, 0x94) |
| byte_valid | input | 1 | A data byte passes the bus this cycle |
| byte_in | input | 8 | Data byte on the bus |
| rd_req | input | 1 | Data register read request |
| rd_valid | output | 1 | rd_data holds a result word |
| rd_data | output | 16 | Result word |

## Verification
A mode write or an accumulated byte takes effect at the clock edge that samples it. A result word becomes visible, together with rd_valid, in the cycle after the edge that sampled rd_req. The bench drives every input on the falling edge and holds it for one full cycle. It then samples rd_valid and rd_data on the next falling edge, which falls half a cycle after the registering edge. Expected words come from a bench function. The function recomputes both halves' line and column parities from the bytes the bench accumulated, including the wrap at 512.

// File: rtl/ecc_gen_pkg.sv
package ecc_gen_pkg;
  localparam logic [7:0] MODE_CLEAR  = 8'hF4;
  localparam logic [7:0] MODE_ACCUM  = 8'hB4;
  localparam logic [7:0] MODE_RESULT = 8'hD4;
  localparam logic [7:0] MODE_DATA   = 8'h94;

  typedef enum logic [1:0] {
    ST_DATA   = 2'd0,
    ST_ACCUM  = 2'd1,
    ST_RESULT = 2'd2
  } ecc_state_e;
endpackage

// File: rtl/ecc_half_acc.sv
module ecc_half_acc #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8,
  localparam int POS_W = $clog2(DATA_W),
  localparam int LP_W  = 2 * IDX_W,
  localparam int CB_W  = 2 * POS_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [DATA_W-1:0] byte_in,
  input  logic [IDX_W-1:0]  idx,
  output logic [LP_W-1:0]   lp_code,
  output logic [CB_W-1:0]   cp_code
);
  logic [IDX_W-1:0]  odd_q, even_q;
  logic [DATA_W-1:0] col_q;
  logic              bpar;

  assign bpar = ^byte_in;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      odd_q  <= '0;
      even_q <= '0;
      col_q  <= '0;
    end else if (en) begin
      odd_q  <= odd_q  ^ ({IDX_W{bpar}} & idx);
      even_q <= even_q ^ ({IDX_W{bpar}} & ~idx);
      col_q  <= col_q  ^ byte_in;
    end
  end

  for (genvar k = 0; k < IDX_W; k++) begin : g_lp
    assign lp_code[2*k+1] = ~odd_q[k];
    assign lp_code[2*k]   = ~even_q[k];
  end

  always_comb begin
    cp_code = '1;
    for (int j = 0; j < POS_W; j++) begin
      logic hi, lo;
      hi = 1'b0;
      lo = 1'b0;
      for (int b = 0; b < DATA_W; b++) begin
        if (((b >> j) & 1) == 1) hi = hi ^ col_q[b];
        else                     lo = lo ^ col_q[b];
      end
      cp_code[2*j+3] = ~hi;
      cp_code[2*j+2] = ~lo;
    end
  end

  // R2: a clear leaves an all-ones code
  a_r2_clear_ones: assert property (@(posedge clk) disable iff (rst)
    clr |=> ((&lp_code) && (&cp_code)));
  // R6: the two low column bits stay set
  a_r6_cp_low_ones: assert property (@(posedge clk) disable iff (rst)
    cp_code[1:0] == 2'b11);
endmodule

// File: rtl/ecc_mode_ctrl.sv
module ecc_mode_ctrl
  import ecc_gen_pkg::*;
#(
  parameter int CNT_W  = 9,
  parameter int NWORDS = 3,
  localparam int WI_W  = $clog2(NWORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_we,
  input  logic [7:0]       mode_code,
  input  logic             byte_valid,
  input  logic             rd_req,
  output ecc_state_e       state,
  output logic             clr,
  output logic             acc_en,
  output logic [CNT_W-1:0] byte_cnt,
  output logic             word_rd,
  output logic [WI_W-1:0]  word_idx
);
  logic pend_q;

  assign clr     = mode_we && (mode_code == MODE_CLEAR);
  assign acc_en  = (state == ST_ACCUM) && byte_valid && !pend_q;
  assign word_rd = (state == ST_RESULT) && rd_req && !pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_DATA;
      pend_q   <= 1'b0;
      byte_cnt <= '0;
      word_idx <= '0;
    end else begin
      if (acc_en) byte_cnt <= byte_cnt + 1'b1;
      if (word_rd)
        word_idx <= (word_idx == WI_W'(NWORDS - 1)) ? '0 : word_idx + 1'b1;
      if (rd_req && pend_q) pend_q <= 1'b0;
      if (mode_we) begin
        case (mode_code)
          MODE_CLEAR: begin
            state    <= ST_DATA;
            pend_q   <= 1'b1;
            byte_cnt <= '0;
          end
          MODE_ACCUM:  if (!pend_q) state <= ST_ACCUM;
          MODE_RESULT: begin
            state    <= ST_RESULT;
            word_idx <= '0;
          end
          MODE_DATA:   state <= ST_DATA;
          default: ;
        endcase
      end
    end
  end

  // R2: accumulate code ignored while a reset is pending
  a_r2_accum_blocked: assert property (@(posedge clk) disable iff (rst)
    (mode_we && mode_code == MODE_ACCUM && pend_q && !rd_req) |=> (state != ST_ACCUM));
  // R4: byte counter wraps to zero
  a_r4_cnt_wrap: assert property (@(posedge clk) disable iff (rst)
    (acc_en && (&byte_cnt) && !mode_we) |=> (byte_cnt == '0));
  // R8: readout index returns to word 0 after the last word
  a_r8_idx_wrap: assert property (@(posedge clk) disable iff (rst)
    (word_rd && word_idx == WI_W'(NWORDS - 1) && !mode_we) |=> (word_idx == '0));
  // R8: readout index never exceeds the last word
  a_r8_idx_range: assert property (@(posedge clk) disable iff (rst)
    word_idx <= WI_W'(NWORDS - 1));
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import ecc_gen_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int HALF_BYTES  = SECTOR_BYTES / 2,
  localparam int IDX_W       = $clog2(HALF_BYTES),
  localparam int CNT_W       = IDX_W + 1,
  localparam int NHALF       = 2,
  localparam int NWORDS      = 3,
  localparam int WI_W        = $clog2(NWORDS)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mode_we,
  input  logic [7:0]  mode_code,
  input  logic        byte_valid,
  input  logic [7:0]  byte_in,
  input  logic        rd_req,
  output logic        rd_valid,
  output logic [15:0] rd_data
);
  ecc_state_e       state;
  logic             clr, acc_en, word_rd;
  logic [CNT_W-1:0] byte_cnt;
  logic [WI_W-1:0]  word_idx;
  logic [2*IDX_W-1:0] lp [NHALF];
  logic [7:0]         cp [NHALF];
  logic [15:0]        word_sel;

  ecc_mode_ctrl #(.CNT_W(CNT_W), .NWORDS(NWORDS)) u_ctrl (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_code(mode_code),
    .byte_valid(byte_valid), .rd_req(rd_req), .state(state), .clr(clr),
    .acc_en(acc_en), .byte_cnt(byte_cnt), .word_rd(word_rd), .word_idx(word_idx)
  );

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    ecc_half_acc #(.DATA_W(8), .IDX_W(IDX_W)) u_half (
      .clk(clk), .rst(rst), .clr(clr),
      .en(acc_en && (byte_cnt[IDX_W] == 1'(h))),
      .byte_in(byte_in), .idx(byte_cnt[IDX_W-1:0]),
      .lp_code(lp[h]), .cp_code(cp[h])
    );
  end

  always_comb begin
    case (word_idx)
      WI_W'(0): word_sel = {lp[0][15:8], lp[0][7:0]};
      WI_W'(1): word_sel = {lp[1][7:0], cp[0]};
      default:  word_sel = {cp[1], lp[1][15:8]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= word_rd;
      rd_data  <= word_rd ? word_sel : '0;
    end
  end

  // R8: a result word appears only one cycle after a request
  a_r8_valid_after_req: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_req));
  // R9: no result words outside readout mode
  a_r9_no_valid_in_data: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA && !mode_we) |=> !rd_valid);
endmodule

// File: tb/tb_nand_ecc_gen.sv
`timescale 1ns/1ps
module tb_nand_ecc_gen;
  logic clk = 1'b0, rst = 1'b1;
  logic mode_we = 1'b0, byte_valid = 1'b0, rd_req = 1'b0;
  logic [7:0] mode_code = 8'h00, byte_in = 8'h00;
  logic rd_valid;
  logic [15:0] rd_data;

  int checks = 0, errors = 0;
  logic [7:0] buf_q [0:1023];
  int nbytes = 0;
  logic [15:0] exp_w [0:2];
  bit done = 1'b0;
  int cyc = 0;

  always #4 clk = ~clk;

  nand_ecc_gen dut (.clk(clk), .rst(rst), .mode_we(mode_we), .mode_code(mode_code),
    .byte_valid(byte_valid), .byte_in(byte_in), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_data(rd_data));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R1 watchdog expired: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compute_expected();
    logic [7:0] lo [2], hi [2], col [2];
    logic [7:0] cb [2];
    logic [15:0] lpv [2];
    for (int h = 0; h < 2; h++) begin lo[h] = 0; hi[h] = 0; col[h] = 0; end
    for (int i = 0; i < nbytes; i++) begin
      int p, h, ix;
      p = buf_q[i] % 512;
      h = ((i % 512) >= 256) ? 1 : 0;
      ix = i % 256;
      p = ^buf_q[i];
      for (int k = 0; k < 8; k++)
        if (((ix >> k) & 1) == 1) hi[h][k] = hi[h][k] ^ p[0];
        else lo[h][k] = lo[h][k] ^ p[0];
      col[h] = col[h] ^ buf_q[i];
    end
    for (int h = 0; h < 2; h++) begin
      for (int k = 0; k < 8; k++) begin
        lpv[h][2*k+1] = ~hi[h][k];
        lpv[h][2*k]   = ~lo[h][k];
      end
      cb[h] = 8'hFF;
      for (int j = 0; j < 3; j++) begin
        logic a, b;
        a = 0; b = 0;
        for (int t = 0; t < 8; t++)
          if (((t >> j) & 1) == 1) a = a ^ col[h][t]; else b = b ^ col[h][t];
        cb[h][2*j+3] = ~a;
        cb[h][2*j+2] = ~b;
      end
    end
    exp_w[0] = lpv[0];
    exp_w[1] = {lpv[1][7:0], cb[0]};
    exp_w[2] = {cb[1], lpv[1][15:8]};
  endtask

  task automatic mode_write(input logic [7:0] c);
    @(negedge clk); mode_we = 1'b1; mode_code = c;
    @(negedge clk); mode_we = 1'b0; mode_code = 8'h00;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); byte_valid = 1'b1; byte_in = b;
    @(negedge clk); byte_valid = 1'b0;
  endtask

  task automatic do_read(output logic v, output logic [15:0] d);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0; v = rd_valid; d = rd_data;
  endtask

  task automatic start_sector();
    logic v; logic [15:0] d;
    mode_write(8'hF4);
    do_read(v, d);
    chk("R2 dummy read no valid", {31'b0, v}, 32'd0);
    mode_write(8'hB4);
    nbytes = 0;
  endtask

  task automatic feed(input int n);
    for (int i = 0; i < n; i++) push(buf_q[i]);
    nbytes = n;
  endtask

  task automatic read_all(input string req);
    logic v; logic [15:0] d;
    compute_expected();
    mode_write(8'hD4);
    for (int w = 0; w < 3; w++) begin
      do_read(v, d);
      chk({req, " valid"}, {31'b0, v}, 32'd1);
      chk({req, " word"}, {16'b0, d}, {16'b0, exp_w[w]});
    end
  endtask

  initial begin
    logic v; logic [15:0] d;
    int s;
    s = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset rd_valid", {31'b0, rd_valid}, 32'd0);
    nbytes = 0;
    read_all("R1 reset readout");

    // R10 erased sector
    start_sector();
    for (int i = 0; i < 512; i++) buf_q[i] = 8'hFF;
    feed(512);
    read_all("R10 erased");

    // R5 R6 R7 single-bit directed patterns
    start_sector();
    buf_q[0] = 8'h01; feed(1);
    read_all("R5 single byte half A");
    start_sector();
    for (int i = 0; i < 300; i++) buf_q[i] = 8'h00;
    buf_q[299] = 8'h80; feed(300);
    read_all("R6 bit7 in half B");

    // R4 R5 R6 R7 random sectors
    for (int r = 0; r < 3; r++) begin
      start_sector();
      for (int i = 0; i < 512; i++) buf_q[i] = 8'($urandom);
      feed(512);
      read_all("R7 random sector");
    end

    // R8 readout wraps to word 0
    do_read(v, d);
    chk("R8 fourth read returns word0", {15'b0, v, d}, {15'b0, 1'b1, exp_w[0]});

    // R4 wrap at 512
    start_sector();
    for (int i = 0; i < 520; i++) buf_q[i] = 8'($urandom);
    feed(520);
    read_all("R4 wrap");

    // R9 data mode leaves readout
    mode_write(8'h94);
    do_read(v, d);
    chk("R9 no valid after data mode", {31'b0, v}, 32'd0);
    mode_write(8'hD4);
    do_read(v, d);
    chk("R9 readout restarts at word0", {16'b0, d}, {16'b0, exp_w[0]});

    // R2 accumulate ignored before dummy read
    mode_write(8'hF4);
    mode_write(8'hB4);
    for (int i = 0; i < 8; i++) push(8'($urandom) | 8'h01);
    do_read(v, d);
    mode_write(8'hB4);
    nbytes = 0;
    read_all("R2 blocked accumulate");

    // R3 bytes in data mode ignored, resume keeps state
    start_sector();
    for (int i = 0; i < 512; i++) buf_q[i] = 8'($urandom);
    for (int i = 0; i < 200; i++) push(buf_q[i]);
    mode_write(8'h94);
    for (int i = 0; i < 10; i++) push(8'h5B);
    mode_write(8'hB4);
    for (int i = 200; i < 512; i++) push(buf_q[i]);
    nbytes = 512;
    read_all("R3 resume after data mode");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule